// File: doc/BRIEF.md
# Receive destination address filter

This block watches the byte stream of an incoming Ethernet frame and decides, from the destination address in its first six bytes, whether the frame is kept or dropped. It compares the destination with a programmed station address and with the all-ones broadcast address. When neither matches, it can still admit the frame through a 64-bit multicast hash table. A promiscuous setting admits every frame without looking at the address. A master receive enable overrides all of these.

Bytes arrive one per cycle, qualified by a valid flag. A start flag marks the first byte of a frame and an end flag marks its last byte. The decision is a one-cycle strobe with an accept bit, issued on the cycle after the sixth byte is taken. A frame that ends before its sixth byte is reported as rejected. Frame storage and transfer to memory sit downstream and are not part of this block.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are low, and they stay low until a frame delivers its sixth byte or ends early.
- R2: When `rx_cfg` bit 0 (receive enable) is clear, every decision is a reject.
- R3: When receive is enabled and `rx_cfg` bit 6 (promiscuous) is set, every frame that reaches six bytes is accepted, whatever its address and hash table.
- R4: A destination equal to the station address is accepted. The address is held high byte first: `addr_w0[15:8]`, `addr_w0[7:0]`, `addr_w1[15:8]`, `addr_w1[7:0]`, `addr_w2[15:8]` and `addr_w2[7:0]` are destination bytes 0 to 5, in that order.
- R5: A destination of six 0xFF bytes is accepted as broadcast.
- R6: With no exact or broadcast match and `rx_cfg` bit 11 (hash enable) set, the hash index is bits 31:26 of a CRC-32 taken over the six destination bytes. The CRC uses the reflected polynomial 0xEDB88320, shifts each byte in LSB first, starts from all ones and is not inverted. Index bits 5:4 select `hash_w0`..`hash_w3` (value k selects `hash_wk`), and index bits 3:0 select the bit within that word. A set bit accepts the frame.
- R7: If the selected hash bit is clear, the frame is rejected. If there is no exact or broadcast match and hashing is disabled, the frame is also rejected.
- R8: `dec_valid` pulses for exactly one cycle, the cycle after the sixth byte is taken. Bytes after the sixth, and bytes outside a frame, cause no decision.
- R9: If the end flag comes with byte 1 to 5 of a frame, a reject strobe follows one cycle later.
- R10: A start flag in the middle of a header drops the partial header, and the frame is decided from the bytes that follow the new start.
- R11: `dec_accept` is never high while `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A byte is on `byte_data` this cycle |
| byte_sof | input | 1 | This byte is the first of a frame |
| byte_eof | input | 1 | This byte is the last of a frame |
| byte_data | input | 8 | Received byte |
| addr_w0 | input | 16 | Station address bytes 0 (high) and 1 (low) |
| addr_w1 | input | 16 | Station address bytes 2 (high) and 3 (low) |
| addr_w2 | input | 16 | Station address bytes 4 (high) and 5 (low) |
| hash_w0 | input | 16 | Hash table word for index bits 5:4 = 0 |
| hash_w1 | input | 16 | Hash table word for index bits 5:4 = 1 |
| hash_w2 | input | 16 | Hash table word for index bits 5:4 = 2 |
| hash_w3 | input | 16 | Hash table word for index bits 5:4 = 3 |
| rx_cfg | input | 16 | Receive configuration: bit 0 enable, bit 6 promiscuous, bit 11 hash enable |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Accept (1) or reject (0), valid with `dec_valid` |

## Verification
The bench sends station-address frames with a single byte wrong, sometimes only the last one and sometimes with byte pairs swapped. A design that mapped a register's halves the wrong way, or that decided before the last byte, would accept these. It programs one hash bit per multicast address, computed from the reflected, non-inverted CRC. A design that reversed the word order, inverted the CRC or took the wrong index bits would then reject a frame it should keep, or keep a frame it should reject. Runt frames, a restart in the middle of a header, trailing bytes and promiscuous mode with the enable cleared check the strobe timing, which a design with an off-by-one byte count or a forgotten enable would break.

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter logic [31:0] CRC_POLY = 32'hEDB88320,
  parameter int          EN_BIT   = 0,
  parameter int          PROM_BIT = 6,
  parameter int          HEN_BIT  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic        byte_sof,
  input  logic        byte_eof,
  input  logic [7:0]  byte_data,
  input  logic [15:0] addr_w0,
  input  logic [15:0] addr_w1,
  input  logic [15:0] addr_w2,
  input  logic [15:0] hash_w0,
  input  logic [15:0] hash_w1,
  input  logic [15:0] hash_w2,
  input  logic [15:0] hash_w3,
  input  logic [15:0] rx_cfg,
  output logic        dec_valid,
  output logic        dec_accept
);
  localparam int HDR_LEN = 6;
  localparam int POS_W   = $clog2(HDR_LEN + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(HDR_LEN - 1);

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  logic [POS_W-1:0] pos_q;
  logic             act_q;
  logic [31:0]      crc_q;
  logic             stn_q, bc_q;

  wire              take     = byte_valid && (byte_sof || act_q);
  wire [POS_W-1:0]  cur_pos  = byte_sof ? '0 : pos_q;
  wire              hdr_done = take && (cur_pos == LAST_POS);
  wire              runt     = take && byte_eof && (cur_pos < LAST_POS);

  wire [31:0] crc_in = byte_sof ? 32'hFFFF_FFFF : crc_q;
  wire        stn_in = byte_sof ? 1'b1 : stn_q;
  wire        bc_in  = byte_sof ? 1'b1 : bc_q;

  logic [7:0] exp_byte;
  always_comb begin
    case (cur_pos)
      3'd0:    exp_byte = addr_w0[15:8];
      3'd1:    exp_byte = addr_w0[7:0];
      3'd2:    exp_byte = addr_w1[15:8];
      3'd3:    exp_byte = addr_w1[7:0];
      3'd4:    exp_byte = addr_w2[15:8];
      default: exp_byte = addr_w2[7:0];
    endcase
  end

  wire [31:0] crc_nx = crc_byte(crc_in, byte_data);
  wire        stn_nx = stn_in && (byte_data == exp_byte);
  wire        bc_nx  = bc_in && (byte_data == 8'hFF);
  wire [5:0]  idx    = crc_nx[31:26];

  logic [15:0] hword;
  always_comb begin
    case (idx[5:4])
      2'd0:    hword = hash_w0;
      2'd1:    hword = hash_w1;
      2'd2:    hword = hash_w2;
      default: hword = hash_w3;
    endcase
  end

  wire hash_hit = rx_cfg[HEN_BIT] && hword[idx[3:0]];
  wire accept_c = rx_cfg[EN_BIT] && (rx_cfg[PROM_BIT] || stn_nx || bc_nx || hash_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q      <= '0;
      act_q      <= 1'b0;
      crc_q      <= '1;
      stn_q      <= 1'b0;
      bc_q       <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= hdr_done || runt;
      dec_accept <= hdr_done && accept_c;
      if (take) begin
        pos_q <= cur_pos + 1'b1;
        act_q <= (cur_pos < LAST_POS) && !byte_eof;
        crc_q <= crc_nx;
        stn_q <= stn_nx;
        bc_q  <= bc_nx;
      end
    end
  end
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic        byte_sof,
  input logic        byte_eof,
  input logic [15:0] rx_cfg,
  input logic        dec_valid,
  input logic        dec_accept
);
  logic [2:0] p;
  logic       act;
  wire        tk = byte_valid && (byte_sof || act);
  wire [2:0]  cp = byte_sof ? 3'd0 : p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p   <= 3'd0;
      act <= 1'b0;
    end else if (tk) begin
      p   <= cp + 3'd1;
      act <= (cp < 3'd5) && !byte_eof;
    end
  end

  AST_HDR_DECIDES: assert property (@(posedge clk) disable iff (!rst_n) (tk && cp == 3'd5) |=> dec_valid); // R8
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n) !(tk && (cp == 3'd5 || byte_eof)) |=> !dec_valid); // R8
  AST_RUNT_REJECTS: assert property (@(posedge clk) disable iff (!rst_n) (tk && byte_eof && cp < 3'd5) |=> (dec_valid && !dec_accept)); // R9
  AST_DISABLED_REJECTS: assert property (@(posedge clk) disable iff (!rst_n) (byte_valid && !rx_cfg[0]) |=> !dec_accept); // R2
  AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n) (tk && cp == 3'd5 && rx_cfg[0] && rx_cfg[6]) |=> dec_accept); // R3
  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) dec_accept |-> dec_valid); // R11
endmodule

bind rx_dest_filter rx_dest_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_sof(byte_sof),
  .byte_eof(byte_eof), .rx_cfg(rx_cfg), .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0, byte_sof = 1'b0, byte_eof = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic [15:0] addr_w0 = 16'h0A1B, addr_w1 = 16'h2C3D, addr_w2 = 16'h4E5F;
  logic [15:0] hash_w0 = 0, hash_w1 = 0, hash_w2 = 0, hash_w3 = 0;
  logic [15:0] rx_cfg = 16'h0001;
  logic        dec_valid, dec_accept;

  localparam logic [15:0] C_EN = 16'h0001, C_PROM = 16'h0040, C_HEN = 16'h0800;

  always #4 clk = ~clk;

  rx_dest_filter dut_i (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_sof(byte_sof),
    .byte_eof(byte_eof), .byte_data(byte_data), .addr_w0(addr_w0), .addr_w1(addr_w1),
    .addr_w2(addr_w2), .hash_w0(hash_w0), .hash_w1(hash_w1), .hash_w2(hash_w2),
    .hash_w3(hash_w3), .rx_cfg(rx_cfg), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  int    n_tests = 0, n_fail = 0, cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (b[k])
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ b[k][i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c;
  endfunction

  function automatic bit ref_decide(input logic [7:0] b[$]);
    logic [47:0] stn = {addr_w0, addr_w1, addr_w2};
    logic [63:0] tbl = {hash_w3, hash_w2, hash_w1, hash_w0};
    bit exact = 1, bcast = 1;
    int idx;
    for (int k = 0; k < 6; k++) begin
      if (b[k] != stn[47 - 8*k -: 8]) exact = 0;
      if (b[k] != 8'hFF) bcast = 0;
    end
    idx = int'(ref_crc(b) >> 26);
    if (!rx_cfg[0]) return 0;
    if (rx_cfg[6] || exact || bcast) return 1;
    return rx_cfg[11] && tbl[idx];
  endfunction

  // Behavioural reference, updated at each rising edge
  logic [7:0] hdr[$];
  bit in_frame = 0, exp_v = 0, exp_a = 0;
  always @(posedge clk) begin
    exp_v = 0; exp_a = 0;
    if (!rst_n) begin
      hdr.delete(); in_frame = 0;
    end else if (byte_valid) begin
      if (byte_sof) begin hdr.delete(); in_frame = 1; end
      if (in_frame) begin
        hdr.push_back(byte_data);
        if (hdr.size() == 6) begin
          exp_v = 1; exp_a = ref_decide(hdr); in_frame = 0;
        end else if (byte_eof) begin
          exp_v = 1; exp_a = 0; in_frame = 0;
        end
      end
    end
  end

  // Compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_v || dec_valid) n_tests++;
      if (dec_valid !== exp_v || dec_accept !== exp_a) begin
        n_fail++;
        $display("FAIL %s: valid/accept actual %b/%b expected %b/%b", cur_req,
                 dec_valid, dec_accept, exp_v, exp_a);
      end
    end
  end

  task automatic send(input logic [7:0] q[$], input bit with_end);
    foreach (q[i]) begin
      @(negedge clk);
      byte_valid = 1; byte_sof = (i == 0);
      byte_eof = with_end && (i == q.size() - 1); byte_data = q[i];
    end
    @(negedge clk);
    byte_valid = 0; byte_sof = 0; byte_eof = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0] f[$];
    logic [5:0] ix;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_tests++;
    if (dec_valid !== 0 || dec_accept !== 0) begin
      n_fail++;
      $display("FAIL R1: actual %b/%b expected 0/0", dec_valid, dec_accept);
    end
    rst_n = 1;
    repeat (3) @(negedge clk);

    cur_req = "R4";
    send('{8'h0A, 8'h1B, 8'h2C, 8'h3D, 8'h4E, 8'h5F, 8'h11, 8'h22}, 1);
    send('{8'h0A, 8'h1B, 8'h2C, 8'h3D, 8'h4E, 8'h5E}, 1);
    send('{8'h1B, 8'h0A, 8'h3D, 8'h2C, 8'h5F, 8'h4E}, 1);
    cur_req = "R5";
    send('{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00}, 1);
    send('{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFE}, 1);

    cur_req = "R2";
    rx_cfg = C_PROM | C_HEN;
    send('{8'h0A, 8'h1B, 8'h2C, 8'h3D, 8'h4E, 8'h5F}, 1);
    send('{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1);

    cur_req = "R3";
    rx_cfg = C_EN | C_PROM;
    send('{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE}, 1);

    cur_req = "R6";
    rx_cfg = C_EN | C_HEN;
    for (int a = 0; a < 12; a++) begin
      f = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'(a * 7), 8'(a * 13 + 1)};
      ix = ref_crc(f) >> 26;
      {hash_w3, hash_w2, hash_w1, hash_w0} = 64'd1 << ix;
      cur_req = "R6";
      send(f, 1);
      cur_req = "R7";
      {hash_w3, hash_w2, hash_w1, hash_w0} = ~(64'd1 << ix);
      send(f, 1);
      rx_cfg = C_EN;
      {hash_w3, hash_w2, hash_w1, hash_w0} = '1;
      send(f, 1);
      rx_cfg = C_EN | C_HEN;
    end
    {hash_w3, hash_w2, hash_w1, hash_w0} = '0;

    cur_req = "R9";
    send('{8'h0A}, 1);
    send('{8'h0A, 8'h1B, 8'h2C, 8'h3D, 8'h4E}, 1);
    rx_cfg = C_EN | C_PROM;
    send('{8'hFF, 8'hFF, 8'hFF}, 1);
    rx_cfg = C_EN;

    cur_req = "R10";
    f = '{8'h77, 8'h66, 8'h55, 8'h0A, 8'h1B, 8'h2C, 8'h3D, 8'h4E, 8'h5F};
    foreach (f[i]) begin
      @(negedge clk);
      byte_valid = 1; byte_sof = (i == 0 || i == 3); byte_eof = 0; byte_data = f[i];
    end
    @(negedge clk); byte_valid = 0; byte_sof = 0;
    repeat (2) @(negedge clk);

    cur_req = "R8";
    foreach (f[i]) begin
      @(negedge clk);
      byte_valid = 1; byte_sof = 0; byte_data = f[i];
    end
    @(negedge clk); byte_valid = 0;
    send('{8'h0A, 8'h1B, 8'h2C, 8'h3D, 8'h4E, 8'h5F, 8'h0A, 8'h1B, 8'h2C, 8'h3D, 8'h4E, 8'h5F}, 0);

    cur_req = "R11";
    send('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06}, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule